// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge and Completion Interface

This block sits between an interrupt distributor and one processor. The distributor supplies three vectors, one entry per interrupt line: pending, enabled and priority. From these the block picks one candidate. The candidate must be pending, enabled and not already active, and its priority must be more urgent than both the processor's programmable priority mask and the priority of the interrupt the processor is currently running. While a candidate exists and group 1 signalling is enabled, the block raises an interrupt request line.

The processor talks to the block through a register-style read port and a register-style write port. Reading the acknowledge register returns the candidate and takes it: the line becomes active, its priority goes onto a small running-priority stack, and a one-cycle acknowledge pulse with the line number tells the distributor to clear that line's pending bit. Reading the peek register returns the same value with no side effect. Completion follows one of two modes. In the combined mode, an end-of-interrupt write both drops the running priority and deactivates the line. In the split mode, the end-of-interrupt write only drops the priority, and a separate deactivate write returns the line to inactive.

Top module: `ackc_cpu_iface`

## Requirements
- R1: After reset the priority mask reads 0xFF, the control register reads 0 with group signalling and split mode both off, `irq` is low, and an acknowledge read returns 1023.
- R2: `irq` stays low, and acknowledge and peek reads return 1023, while the group enable bit (control bit 0) is clear.
- R3: A line qualifies when it is pending, enabled and not active, and its priority value is numerically lower than both the mask and the running priority. The running priority is the top of the stack, or above every 8-bit value when the stack is empty. The lowest priority value wins, and ties go to the lowest line number.
- R4: An acknowledge read (register select 0) returns the winning line number in bits 15:0 with bits 31:16 zero. In the same cycle it pulses `ack_valid` with that number on `ack_id`. It marks the line active and pushes its priority, so the line is not returned again while it stays active.
- R5: A peek read (register select 1) returns the same word as an acknowledge read would, and changes no state.
- R6: When no line qualifies, acknowledge and peek reads return 1023 and `ack_valid` stays low.
- R7: With split mode off (control bit 1 clear), an end-of-interrupt write (register select 2) whose bits 15:0 equal the line at the top of the running stack pops the stack and deactivates that line.
- R8: With split mode on, an end-of-interrupt write only pops the stack and the line stays active. A deactivate write (register select 3) naming an active line clears its active state.
- R9: An end-of-interrupt write naming any line other than the top of the running stack has no effect. A deactivate write has no effect when split mode is off or when the named line is not active.
- R10: While the running stack holds its full depth of entries, no line is signalled or acknowledged.
- R11: The mask (register select 4, bits 7:0) and the control register (register select 5, bit 0 group enable, bit 1 split mode) read back what was last written. Other read selects return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pend | input | N_LINES | Pending flag per line from the distributor |
| line_en | input | N_LINES | Enable flag per line from the distributor |
| line_prio | input | N_LINES*PRIO_W | Priority per line, line i at bits i*PRIO_W +: PRIO_W |
| irq | output | 1 | Interrupt request to the processor |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 3 | Register read select |
| rd_data | output | 32 | Read data, valid in the cycle of the strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 32 | Write data |
| ack_valid | output | 1 | Pulse: a line was acknowledged this cycle |
| ack_id | output | 16 | Acknowledged line number |

## Verification
The bench builds the block with 12 lines, 8-bit priorities and a running stack of depth 3. With a depth of 3 the stack fills after three nested acknowledges, so the full-stack gating of R10 and its release on completion are reached in a short sequence. With 12 lines, a loop over every line makes the lowest-number tie-break cheap to check. The bench keeps its own queue-based model of the active set, the running stack, the mask and the control bits, and compares `irq`, the read data and the acknowledge pulse against it on every cycle.

// File: rtl/ackc_pkg.sv
// Package: shared constants for the acknowledge and completion interface.
// Assumes register selects are 3 bits and returned IDs occupy 16 bits.
package ackc_pkg;
    localparam int ID_W = 16;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 16'd1023;
    localparam logic [ID_W-1:0] FIRST_SPECIAL = 16'd1020;

    localparam logic [2:0] SEL_ACK   = 3'd0;
    localparam logic [2:0] SEL_PEEK  = 3'd1;
    localparam logic [2:0] SEL_EOI   = 3'd2;
    localparam logic [2:0] SEL_DEACT = 3'd3;
    localparam logic [2:0] SEL_MASK  = 3'd4;
    localparam logic [2:0] SEL_CTRL  = 3'd5;

    localparam int CTRL_GRP_BIT   = 0;
    localparam int CTRL_SPLIT_BIT = 1;
endpackage

// File: rtl/ackc_arbiter.sv
// Module: combinational selector of the most urgent eligible line.
// Assumes a lower priority value is more urgent; the scan keeps the first
// (lowest-numbered) line among equals.
module ackc_arbiter #(
    parameter int N  = 32,
    parameter int PW = 8,
    parameter int IW = 5
) (
    input  logic [N-1:0]    pend,
    input  logic [N-1:0]    en,
    input  logic [N-1:0]    act,
    input  logic [N*PW-1:0] prio,
    input  logic [PW:0]     thresh,
    output logic            sel_valid,
    output logic [IW-1:0]   sel_id,
    output logic [PW-1:0]   sel_prio
);
    logic [N-1:0] elig;

    // Per-line eligibility: pending, enabled, inactive and under the threshold.
    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = pend[g] & en[g] & ~act[g] &
                         ({1'b0, prio[g*PW +: PW]} < thresh);
    end

    // Linear scan keeping the strictly lower priority, so ties favour low IDs.
    always_comb begin
        sel_valid = 1'b0;
        sel_id    = '0;
        sel_prio  = '1;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!sel_valid || (prio[i*PW +: PW] < sel_prio))) begin
                sel_valid = 1'b1;
                sel_id    = IW'(i);
                sel_prio  = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/ackc_prio_stack.sv
// Module: running-priority stack of acknowledged but not yet dropped lines.
// Assumes the owner never pushes while full and never pops while empty.
module ackc_prio_stack #(
    parameter int DEPTH = 4,
    parameter int IW    = 5,
    parameter int PW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_id,
    input  logic [PW-1:0] push_prio,
    input  logic          pop,
    output logic [IW-1:0] top_id,
    output logic [PW-1:0] top_prio,
    output logic          empty,
    output logic          full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] cnt;
    logic [IW-1:0] id_q [DEPTH];
    logic [PW-1:0] pr_q [DEPTH];
    logic [AW-1:0] top_ptr;
    logic [AW-1:0] wr_ptr;

    assign top_ptr  = AW'(cnt - CW'(1));
    assign wr_ptr   = pop ? top_ptr : AW'(cnt);
    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign top_id   = id_q[top_ptr];
    assign top_prio = pr_q[top_ptr];

    // Entry storage: a push writes the next slot, or replaces the popped top.
    always_ff @(posedge clk) begin
        if (push) begin
            id_q[wr_ptr] <= push_id;
            pr_q[wr_ptr] <= push_prio;
        end
    end

    // Occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (push && !pop)
            cnt <= cnt + CW'(1);
        else if (pop && !push && !empty)
            cnt <= cnt - CW'(1);
    end

    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R10
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full); // R10
endmodule

// File: rtl/ackc_active_set.sv
// Module: per-line active flags set on acknowledge and cleared on deactivation.
// Assumes a line is never set and cleared in the same cycle.
module ackc_active_set #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  act
);
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;

    // One-hot decode of the set and clear requests.
    for (genvar g = 0; g < N; g++) begin : g_dec
        assign set_vec[g] = set_en && (set_idx == IW'(g));
        assign clr_vec[g] = clr_en && (clr_idx == IW'(g));
    end

    // Active flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= '0;
        else
            act <= (act & ~clr_vec) | set_vec;
    end

    AST_SET_ONLY_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !act[set_idx]); // R4
endmodule

// File: rtl/ackc_cpu_iface.sv
// Module: per-processor acknowledge / completion interface (top).
// Selects the most urgent qualifying line, raises irq, and tracks each line
// through acknowledge, priority drop and deactivation in combined or split
// completion mode. Assumes at most one register access per cycle and that the
// distributor clears pending on ack_valid. N_LINES must stay below 1020.
module ackc_cpu_iface
    import ackc_pkg::*;
#(
    parameter int N_LINES     = 32,
    parameter int PRIO_W      = 8,
    parameter int STACK_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINES-1:0]        line_pend,
    input  logic [N_LINES-1:0]        line_en,
    input  logic [N_LINES*PRIO_W-1:0] line_prio,
    output logic                      irq,
    input  logic                      rd_en,
    input  logic [2:0]                rd_sel,
    output logic [31:0]               rd_data,
    input  logic                      wr_en,
    input  logic [2:0]                wr_sel,
    input  logic [31:0]               wr_data,
    output logic                      ack_valid,
    output logic [ID_W-1:0]           ack_id
);
    localparam int IDXW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    logic [PRIO_W-1:0] mask_q;
    logic              grp_q;
    logic              split_q;
    logic [N_LINES-1:0] act;
    logic              sel_valid;
    logic [IDXW-1:0]   sel_id;
    logic [PRIO_W-1:0] sel_prio;
    logic              stk_empty;
    logic              stk_full;
    logic [IDXW-1:0]   top_id;
    logic [PRIO_W-1:0] top_prio;
    logic [PRIO_W:0]   run_prio;
    logic [PRIO_W:0]   thresh;
    logic              cand_valid;
    logic              ack_fire;
    logic [ID_W-1:0]   cand_word;
    logic [ID_W-1:0]   wr_id;
    logic [IDXW-1:0]   wr_idx;
    logic              wr_in_range;
    logic              eoi_ok;
    logic              deact_ok;
    logic              clr_en;

    // Running priority: top of stack, or one above every value when idle.
    assign run_prio = stk_empty ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, top_prio};
    // Threshold: the more urgent of mask and running priority.
    assign thresh   = ({1'b0, mask_q} < run_prio) ? {1'b0, mask_q} : run_prio;

    ackc_arbiter #(.N(N_LINES), .PW(PRIO_W), .IW(IDXW)) u_arb (
        .pend     (line_pend),
        .en       (line_en),
        .act      (act),
        .prio     (line_prio),
        .thresh   (thresh),
        .sel_valid(sel_valid),
        .sel_id   (sel_id),
        .sel_prio (sel_prio)
    );

    // Candidate gating: group enable and room on the running stack.
    assign cand_valid = sel_valid && grp_q && !stk_full;
    assign ack_fire   = rd_en && (rd_sel == SEL_ACK) && cand_valid;
    assign cand_word  = cand_valid ? ID_W'(sel_id) : SPURIOUS_ID;

    // Completion decode of the write port.
    assign wr_id       = wr_data[ID_W-1:0];
    assign wr_idx      = wr_id[IDXW-1:0];
    assign wr_in_range = (wr_id < ID_W'(N_LINES));
    assign eoi_ok      = wr_en && (wr_sel == SEL_EOI) && !stk_empty &&
                         (ID_W'(top_id) == wr_id);
    assign deact_ok    = wr_en && (wr_sel == SEL_DEACT) && split_q &&
                         wr_in_range && act[wr_idx];
    assign clr_en      = (eoi_ok && !split_q) || deact_ok;

    ackc_prio_stack #(.DEPTH(STACK_DEPTH), .IW(IDXW), .PW(PRIO_W)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_fire),
        .push_id  (sel_id),
        .push_prio(sel_prio),
        .pop      (eoi_ok),
        .top_id   (top_id),
        .top_prio (top_prio),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    ackc_active_set #(.N(N_LINES), .IW(IDXW)) u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (ack_fire),
        .set_idx(sel_id),
        .clr_en (clr_en),
        .clr_idx(wr_idx),
        .act    (act)
    );

    // Mask and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            grp_q   <= 1'b0;
            split_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel == SEL_MASK)
                mask_q <= wr_data[PRIO_W-1:0];
            if (wr_sel == SEL_CTRL) begin
                grp_q   <= wr_data[CTRL_GRP_BIT];
                split_q <= wr_data[CTRL_SPLIT_BIT];
            end
        end
    end

    // Read mux, valid in the strobe cycle.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_sel)
                SEL_ACK, SEL_PEEK: rd_data = {16'h0, cand_word};
                SEL_MASK:          rd_data = 32'(mask_q);
                SEL_CTRL:          rd_data = {30'h0, split_q, grp_q};
                default:           rd_data = '0;
            endcase
        end
    end

    assign irq       = cand_valid;
    assign ack_valid = ack_fire;
    assign ack_id    = ID_W'(sel_id);

    AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == '1 && !grp_q && !split_q)); // R1
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (line_pend[sel_id] && line_en[sel_id] && !act[sel_id])); // R3
    AST_ACK_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> act[$past(sel_id)]); // R4
    AST_RP_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (run_prio < $past(run_prio))); // R3
    AST_BAD_EOI_KEEPS_RP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_EOI && !eoi_ok && !ack_fire) |=> $stable(run_prio)); // R9
    AST_ID_NOT_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_id < FIRST_SPECIAL)); // R4
endmodule

// File: tb/tb_ackc_cpu_iface.sv
module tb_ackc_cpu_iface;
    localparam int N  = 12;
    localparam int PW = 8;
    localparam int D  = 3;

    logic          clk;
    logic          rst_n;
    logic [N-1:0]  pend;
    logic [N-1:0]  en;
    logic [N*PW-1:0] prio;
    logic          irq;
    logic          rd_en;
    logic [2:0]    rd_sel;
    logic [31:0]   rd_data;
    logic          wr_en;
    logic [2:0]    wr_sel;
    logic [31:0]   wr_data;
    logic          ack_valid;
    logic [15:0]   ack_id;

    int total = 0;
    int bad   = 0;

    // reference model state
    bit m_act [N];
    int stk_id [$];
    int stk_pr [$];
    int m_mask = 255;
    bit m_grp = 0;
    bit m_split = 0;

    ackc_cpu_iface #(.N_LINES(N), .PRIO_W(PW), .STACK_DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .line_pend(pend), .line_en(en),
        .line_prio(prio), .irq(irq), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ack_valid(ack_valid), .ack_id(ack_id)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish (got hung, expected done)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                       input string req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic void model_cand(output bit v, output int id);
        int thr = m_mask;
        int bp = 1000;
        id = -1;
        if (stk_pr.size() > 0 && stk_pr[$] < thr) thr = stk_pr[$];
        for (int i = 0; i < N; i++) begin
            int p = int'(prio[i*PW +: PW]);
            if (pend[i] && en[i] && !m_act[i] && p < thr && p < bp) begin
                id = i;
                bp = p;
            end
        end
        v = m_grp && (id >= 0) && (stk_id.size() < D);
    endfunction

    // One clock of stimulus, comparison against the model, then model update.
    task automatic cyc(input bit re, input logic [2:0] rs, input bit we,
                       input logic [2:0] ws, input logic [31:0] wd, input string req);
        bit v;
        int id;
        logic [31:0] exp_rd;
        bit exp_ack;
        int wid;
        rd_en = re; rd_sel = rs; wr_en = we; wr_sel = ws; wr_data = wd;
        #2;
        model_cand(v, id);
        chk(32'(irq), 32'(v), req, "irq");
        if (re) begin
            case (rs)
                3'd0, 3'd1: exp_rd = v ? 32'(id) : 32'd1023;
                3'd4: exp_rd = 32'(m_mask);
                3'd5: exp_rd = {30'h0, m_split, m_grp};
                default: exp_rd = 32'h0;
            endcase
            chk(rd_data, exp_rd, req, "rd_data");
        end
        exp_ack = re && rs == 3'd0 && v;
        chk(32'(ack_valid), 32'(exp_ack), req, "ack_valid");
        if (exp_ack) chk(32'(ack_id), 32'(id), req, "ack_id");
        @(posedge clk);
        #1;
        if (exp_ack) begin
            m_act[id] = 1'b1;
            stk_id.push_back(id);
            stk_pr.push_back(int'(prio[id*PW +: PW]));
            pend[id] = 1'b0;
        end
        if (we) begin
            wid = int'(wd[15:0]);
            case (ws)
                3'd2: if (stk_id.size() > 0 && stk_id[$] == wid) begin
                    void'(stk_id.pop_back());
                    void'(stk_pr.pop_back());
                    if (!m_split) m_act[wid] = 1'b0;
                end
                3'd3: if (m_split && wid < N && m_act[wid]) m_act[wid] = 1'b0;
                3'd4: m_mask = int'(wd[7:0]);
                3'd5: begin m_grp = wd[0]; m_split = wd[1]; end
                default: ;
            endcase
        end
        rd_en = 0; wr_en = 0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] s, input string req);
        cyc(1, s, 0, 3'd0, 32'h0, req);
    endtask
    task automatic wr(input logic [2:0] s, input logic [31:0] d, input string req);
        cyc(0, 3'd0, 1, s, d, req);
    endtask
    task automatic line(input int i, input int p, input bit pe, input bit e);
        prio[i*PW +: PW] = PW'(p);
        pend[i] = pe;
        en[i] = e;
    endtask

    initial begin
        rst_n = 0; pend = '0; en = '0; prio = '1;
        rd_en = 0; rd_sel = '0; wr_en = 0; wr_sel = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        rd(3'd4, "R1");
        rd(3'd5, "R1");
        rd(3'd0, "R1");
        rd(3'd6, "R11");
        // R2: group enable off blocks signalling
        line(5, 8'h40, 1, 1);
        rd(3'd1, "R2");
        rd(3'd0, "R2");
        // R11 / R5 / R4: enable group, peek twice, acknowledge
        wr(3'd5, 32'h1, "R11");
        rd(3'd5, "R11");
        rd(3'd1, "R5");
        rd(3'd1, "R5");
        rd(3'd0, "R4");
        rd(3'd0, "R6");
        // R9: running priority 0x40 blocks equal priority; wrong EOI ignored
        line(2, 8'h40, 1, 1);
        rd(3'd1, "R3");
        wr(3'd2, 32'd7, "R9");
        rd(3'd1, "R9");
        // R7: correct EOI drops and deactivates
        wr(3'd2, 32'd5, "R7");
        rd(3'd0, "R7");
        line(5, 8'h40, 1, 1);
        wr(3'd2, 32'd2, "R7");
        rd(3'd0, "R7");
        wr(3'd2, 32'd5, "R7");
        // R3: tie on priority goes to lower line, lower value beats lower line
        line(3, 8'h20, 1, 1);
        line(9, 8'h20, 1, 1);
        rd(3'd1, "R3");
        line(10, 8'h10, 1, 1);
        line(1, 8'h30, 1, 1);
        rd(3'd0, "R3");
        wr(3'd2, 32'd10, "R3");
        rd(3'd0, "R3");
        wr(3'd2, 32'd3, "R3");
        rd(3'd0, "R3");
        wr(3'd2, 32'd9, "R3");
        rd(3'd0, "R3");
        wr(3'd2, 32'd1, "R3");
        // R3: mask threshold is strict
        wr(3'd4, 32'h30, "R11");
        rd(3'd4, "R11");
        line(6, 8'h30, 1, 1);
        rd(3'd1, "R3");
        line(6, 8'h2F, 1, 1);
        rd(3'd1, "R3");
        line(7, 8'h2F, 1, 0);
        rd(3'd0, "R3");
        wr(3'd2, 32'd6, "R3");
        wr(3'd4, 32'hFF, "R11");
        // R8: split mode: EOI drops only, deactivate frees the line
        wr(3'd5, 32'h3, "R8");
        line(4, 8'h50, 1, 1);
        rd(3'd0, "R8");
        wr(3'd2, 32'd4, "R8");
        line(4, 8'h50, 1, 1);
        rd(3'd1, "R8");
        wr(3'd3, 32'd8, "R9");
        rd(3'd1, "R9");
        wr(3'd3, 32'd4, "R8");
        rd(3'd1, "R8");
        rd(3'd0, "R8");
        wr(3'd2, 32'd4, "R8");
        wr(3'd3, 32'd4, "R8");
        // R9: deactivate ignored with split off
        wr(3'd5, 32'h1, "R9");
        line(11, 8'h60, 1, 1);
        rd(3'd0, "R9");
        wr(3'd3, 32'd11, "R9");
        line(11, 8'h60, 1, 1);
        wr(3'd2, 32'd11, "R9");
        rd(3'd1, "R9");
        rd(3'd0, "R9");
        wr(3'd2, 32'd11, "R9");
        // R10: stack full blocks a more urgent line until a drop
        line(0, 8'h30, 1, 1);
        rd(3'd0, "R10");
        line(8, 8'h20, 1, 1);
        rd(3'd0, "R10");
        line(5, 8'h10, 1, 1);
        rd(3'd0, "R10");
        line(2, 8'h08, 1, 1);
        rd(3'd1, "R10");
        rd(3'd0, "R10");
        wr(3'd2, 32'd5, "R10");
        rd(3'd0, "R10");
        wr(3'd2, 32'd2, "R10");
        wr(3'd2, 32'd8, "R10");
        wr(3'd2, 32'd0, "R10");
        // R2: group disable again
        line(9, 8'h20, 1, 1);
        wr(3'd5, 32'h0, "R2");
        rd(3'd0, "R2");
        for (int k = 0; k < 4; k++) rd(3'd1, "R6");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule